// File: doc/BRIEF.md
# Priority Transmit Request Scheduler

This block chooses which message object a serial bus protocol core sends next. It holds five flags for each object. The valid flag marks an object as in use. The request flag marks a pending transmission. The new-data flag shows a write since the last load. The interrupt-enable flag asks for an interrupt on success, and the interrupt-pending flag records one. When the core's shift register can accept a frame and the message RAM is not taken by a buffer copy, the scheduler runs a priority search over the pending objects. It hands the winning index to the core as a one-cycle load strobe.

One object is in flight at a time. When the core reports success, the scheduler updates that object's flags and goes back to searching. When the core reports lost arbitration or a bus error, the scheduler waits for the bus to go idle. It then searches again from scratch, so a retried frame competes with any request of higher priority that arrived during the wait. Software sets the flags through a single write port that replaces all five flags of one object at once.

Top module: `txs_sched`

## Requirements
- R1: After reset, every flag vector, `load_o`, `busy_o` and `retry_wait_o` read 0.
- R2: A cycle with `wr_en_i` high replaces all five flags of object `wr_idx_i` with the write inputs. The new values are visible on the flag outputs after that clock edge. If the write lands in the same cycle as a load or completion of the same object, the write wins.
- R3: No load happens in a cycle where `core_ready_i` is low or `ram_busy_i` is high, even if requests are pending.
- R4: When idle with the core ready and the RAM free, the scheduler picks the lowest-numbered object that has both its valid flag and its request flag set. Index 0 has the highest priority. An object whose request flag is set but whose valid flag is clear is skipped. On the next cycle it raises `load_o` for exactly one cycle with that index on `load_idx_o`, and `busy_o` rises.
- R5: The selected object's new-data flag clears on the edge that starts its load.
- R6: Success (`tx_ok_i`) while a frame is in flight clears the object's request flag if its new-data flag is 0, and `busy_o` falls on the next cycle.
- R7: If new data was written to the in-flight object (new-data flag set) before success, its request flag stays 1 after success.
- R8: On success the interrupt-pending flag of the object is set if and only if its interrupt-enable flag is 1.
- R9: Lost arbitration (`arb_lost_i`) or an error (`tx_err_i`) moves the scheduler into a retry wait. `busy_o` and `retry_wait_o` stay high until a cycle with `bus_idle_i` high. The next load then comes from a fresh priority search.
- R10: While `busy_o` is high no new load is issued, even with the core ready and other requests pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one object's flags |
| wr_idx_i | input | IDX_W | Object written |
| wr_msgval_i | input | 1 | New valid flag |
| wr_txrqst_i | input | 1 | New request flag |
| wr_newdat_i | input | 1 | New new-data flag |
| wr_txie_i | input | 1 | New interrupt-enable flag |
| wr_intpnd_i | input | 1 | New interrupt-pending flag |
| ram_busy_i | input | 1 | Buffer-to-RAM transfer in progress |
| core_ready_i | input | 1 | Core shift register can accept a frame |
| tx_ok_i | input | 1 | In-flight frame sent successfully |
| arb_lost_i | input | 1 | In-flight frame lost arbitration |
| tx_err_i | input | 1 | In-flight frame hit a bus error |
| bus_idle_i | input | 1 | Bus is free |
| load_o | output | 1 | One-cycle load strobe to the core |
| load_idx_o | output | IDX_W | Index of the object being sent |
| busy_o | output | 1 | A frame is in flight or waiting for retry |
| retry_wait_o | output | 1 | Waiting for an idle bus before re-searching |
| msgval_o | output | NUM_OBJ | Valid flags |
| txrqst_o | output | NUM_OBJ | Request flags |
| newdat_o | output | NUM_OBJ | New-data flags |
| txie_o | output | NUM_OBJ | Interrupt-enable flags |
| intpnd_o | output | NUM_OBJ | Interrupt-pending flags |

## Verification
The bench builds the scheduler with `NUM_OBJ` set to 8, so `IDX_W` is 3. At that size both ends of the priority range can be exercised: it runs a contest between object 0 and object 7 and skips a requested but invalid object in between. The smaller vector also lets a few directed writes place a new higher-priority request during a retry wait. That shows the retry re-entering the search rather than repeating the failed index. The search logic is the same at the default width of 32.

// File: rtl/txs_pkg.sv
package txs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_RETRY  = 2'd2
    } txs_state_e;

endpackage

// File: rtl/txs_prio_enc.sv
module txs_prio_enc #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    // Scan from high to low so the lowest set bit is the last one written.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/txs_decode.sv
module txs_decode #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic          en_i,
    input  logic [IW-1:0] idx_i,
    output logic [N-1:0]  sel_o
);

    for (genvar g = 0; g < N; g++) begin : g_sel
        assign sel_o[g] = en_i && (idx_i == IW'(g));
    end

endmodule

// File: rtl/txs_sched.sv
module txs_sched
    import txs_pkg::*;
#(
    parameter int NUM_OBJ = 32,
    localparam int IDX_W  = $clog2(NUM_OBJ)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic               wr_msgval_i,
    input  logic               wr_txrqst_i,
    input  logic               wr_newdat_i,
    input  logic               wr_txie_i,
    input  logic               wr_intpnd_i,
    input  logic               ram_busy_i,
    input  logic               core_ready_i,
    input  logic               tx_ok_i,
    input  logic               arb_lost_i,
    input  logic               tx_err_i,
    input  logic               bus_idle_i,
    output logic               load_o,
    output logic [IDX_W-1:0]   load_idx_o,
    output logic               busy_o,
    output logic               retry_wait_o,
    output logic [NUM_OBJ-1:0] msgval_o,
    output logic [NUM_OBJ-1:0] txrqst_o,
    output logic [NUM_OBJ-1:0] newdat_o,
    output logic [NUM_OBJ-1:0] txie_o,
    output logic [NUM_OBJ-1:0] intpnd_o
);

    typedef struct packed {
        logic [NUM_OBJ-1:0] msgval;
        logic [NUM_OBJ-1:0] txrqst;
        logic [NUM_OBJ-1:0] newdat;
        logic [NUM_OBJ-1:0] txie;
        logic [NUM_OBJ-1:0] intpnd;
        txs_state_e         st;
        logic [IDX_W-1:0]   idx;
        logic               load;
    } sched_t;

    sched_t r_q, r_d;

    logic [NUM_OBJ-1:0] pend;
    logic               win_found;
    logic [IDX_W-1:0]   win_idx;
    logic               grant;
    logic [NUM_OBJ-1:0] win_sel;
    logic [NUM_OBJ-1:0] cur_sel;
    logic [NUM_OBJ-1:0] wr_sel;

    assign pend  = r_q.msgval & r_q.txrqst;
    assign grant = (r_q.st == ST_IDLE) && core_ready_i && !ram_busy_i && win_found;

    txs_prio_enc #(.N(NUM_OBJ), .IW(IDX_W)) u_prio (
        .req_i   (pend),
        .found_o (win_found),
        .idx_o   (win_idx)
    );

    txs_decode #(.N(NUM_OBJ), .IW(IDX_W)) u_dec_win (
        .en_i  (grant),
        .idx_i (win_idx),
        .sel_o (win_sel)
    );

    txs_decode #(.N(NUM_OBJ), .IW(IDX_W)) u_dec_cur (
        .en_i  (1'b1),
        .idx_i (r_q.idx),
        .sel_o (cur_sel)
    );

    txs_decode #(.N(NUM_OBJ), .IW(IDX_W)) u_dec_wr (
        .en_i  (wr_en_i),
        .idx_i (wr_idx_i),
        .sel_o (wr_sel)
    );

    always_comb begin
        r_d      = r_q;
        r_d.load = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (grant) begin
                    r_d.st     = ST_ACTIVE;
                    r_d.idx    = win_idx;
                    r_d.load   = 1'b1;
                    r_d.newdat = r_q.newdat & ~win_sel;
                end
            end
            ST_ACTIVE: begin
                if (tx_ok_i) begin
                    if (!r_q.newdat[r_q.idx]) begin
                        r_d.txrqst = r_q.txrqst & ~cur_sel;
                    end
                    if (r_q.txie[r_q.idx]) begin
                        r_d.intpnd = r_q.intpnd | cur_sel;
                    end
                    r_d.st = ST_IDLE;
                end else if (arb_lost_i || tx_err_i) begin
                    r_d.st = ST_RETRY;
                end
            end
            ST_RETRY: begin
                if (bus_idle_i) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        // Software write is applied last and takes precedence.
        r_d.msgval = (r_d.msgval & ~wr_sel) | (wr_sel & {NUM_OBJ{wr_msgval_i}});
        r_d.txrqst = (r_d.txrqst & ~wr_sel) | (wr_sel & {NUM_OBJ{wr_txrqst_i}});
        r_d.newdat = (r_d.newdat & ~wr_sel) | (wr_sel & {NUM_OBJ{wr_newdat_i}});
        r_d.txie   = (r_d.txie   & ~wr_sel) | (wr_sel & {NUM_OBJ{wr_txie_i}});
        r_d.intpnd = (r_d.intpnd & ~wr_sel) | (wr_sel & {NUM_OBJ{wr_intpnd_i}});
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.msgval <= '0;
            r_q.txrqst <= '0;
            r_q.newdat <= '0;
            r_q.txie   <= '0;
            r_q.intpnd <= '0;
            r_q.st     <= ST_IDLE;
            r_q.idx    <= '0;
            r_q.load   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign load_o       = r_q.load;
    assign load_idx_o   = r_q.idx;
    assign busy_o       = (r_q.st != ST_IDLE);
    assign retry_wait_o = (r_q.st == ST_RETRY);
    assign msgval_o     = r_q.msgval;
    assign txrqst_o     = r_q.txrqst;
    assign newdat_o     = r_q.newdat;
    assign txie_o       = r_q.txie;
    assign intpnd_o     = r_q.intpnd;

endmodule

// File: rtl/txs_sched_chk.sv
module txs_sched_chk #(
    parameter int NUM_OBJ = 32,
    localparam int IDX_W  = $clog2(NUM_OBJ)
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               wr_en_i,
    input logic [IDX_W-1:0]   wr_idx_i,
    input logic               ram_busy_i,
    input logic               core_ready_i,
    input logic               tx_ok_i,
    input logic               bus_idle_i,
    input logic               load_o,
    input logic [IDX_W-1:0]   load_idx_o,
    input logic               busy_o,
    input logic               retry_wait_o,
    input logic [NUM_OBJ-1:0] msgval_o,
    input logic [NUM_OBJ-1:0] txrqst_o,
    input logic [NUM_OBJ-1:0] newdat_o
);

    logic [NUM_OBJ-1:0] pend_prev;
    logic               wr_en_prev;
    logic [IDX_W-1:0]   wr_idx_prev;
    logic [NUM_OBJ-1:0] below;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_prev   <= '0;
            wr_en_prev  <= 1'b0;
            wr_idx_prev <= '0;
        end else begin
            pend_prev   <= msgval_o & txrqst_o;
            wr_en_prev  <= wr_en_i;
            wr_idx_prev <= wr_idx_i;
        end
    end

    assign below = (NUM_OBJ'(1) << load_idx_o) - NUM_OBJ'(1);

    a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_o |=> !load_o);

    a_r4_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_o |-> pend_prev[load_idx_o]);

    a_r4_lowest_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_o |-> ((pend_prev & below) == '0));

    a_r3_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_o |-> $past(core_ready_i && !ram_busy_i));

    a_r10_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_o |-> !$past(busy_o));

    a_r5_newdat_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_o && !(wr_en_prev && wr_idx_prev == load_idx_o)) |-> !newdat_o[load_idx_o]);

    a_r6_success_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !retry_wait_o && tx_ok_i) |=> !busy_o);

    a_r9_hold_retry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (retry_wait_o && !bus_idle_i) |=> (retry_wait_o && busy_o));

endmodule

bind txs_sched txs_sched_chk #(.NUM_OBJ(NUM_OBJ)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_idx_i     (wr_idx_i),
    .ram_busy_i   (ram_busy_i),
    .core_ready_i (core_ready_i),
    .tx_ok_i      (tx_ok_i),
    .bus_idle_i   (bus_idle_i),
    .load_o       (load_o),
    .load_idx_o   (load_idx_o),
    .busy_o       (busy_o),
    .retry_wait_o (retry_wait_o),
    .msgval_o     (msgval_o),
    .txrqst_o     (txrqst_o),
    .newdat_o     (newdat_o)
);

// File: tb/txs_sched_bench.sv
module txs_sched_bench;

    localparam int N  = 8;
    localparam int IW = $clog2(N);

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [IW-1:0] wr_idx_i = '0;
    logic          wr_msgval_i = 1'b0;
    logic          wr_txrqst_i = 1'b0;
    logic          wr_newdat_i = 1'b0;
    logic          wr_txie_i = 1'b0;
    logic          wr_intpnd_i = 1'b0;
    logic          ram_busy_i = 1'b0;
    logic          core_ready_i = 1'b0;
    logic          tx_ok_i = 1'b0;
    logic          arb_lost_i = 1'b0;
    logic          tx_err_i = 1'b0;
    logic          bus_idle_i = 1'b0;
    logic          load_o;
    logic [IW-1:0] load_idx_o;
    logic          busy_o;
    logic          retry_wait_o;
    logic [N-1:0]  msgval_o, txrqst_o, newdat_o, txie_o, intpnd_o;

    int checks = 0;
    int errors = 0;

    always #2 clk_i = ~clk_i;

    txs_sched #(.NUM_OBJ(N)) u_txs_sched (
        .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_msgval_i, .wr_txrqst_i,
        .wr_newdat_i, .wr_txie_i, .wr_intpnd_i, .ram_busy_i, .core_ready_i,
        .tx_ok_i, .arb_lost_i, .tx_err_i, .bus_idle_i, .load_o, .load_idx_o,
        .busy_o, .retry_wait_o, .msgval_o, .txrqst_o, .newdat_o, .txie_o,
        .intpnd_o
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk_i);
    endtask

    task automatic write_obj(input int idx, input logic mv, input logic rq,
                             input logic nd, input logic ie, input logic ip);
        wr_en_i = 1'b1; wr_idx_i = IW'(idx);
        wr_msgval_i = mv; wr_txrqst_i = rq; wr_newdat_i = nd;
        wr_txie_i = ie; wr_intpnd_i = ip;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic pulse_ok();
        tx_ok_i = 1'b1; tick(); tx_ok_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 msgval", 32'(msgval_o), 0);
        chk("R1 txrqst", 32'(txrqst_o), 0);
        chk("R1 intpnd", 32'(intpnd_o | newdat_o | txie_o), 0);
        chk("R1 load/busy", {29'd0, load_o, busy_o, retry_wait_o}, 0);
    endtask

    task automatic t_write();
        write_obj(5, 1, 1, 1, 1, 0);
        chk("R2 obj5 flags", {27'd0, msgval_o[5], txrqst_o[5], newdat_o[5], txie_o[5], intpnd_o[5]}, 32'b11110);
        write_obj(2, 0, 1, 0, 0, 0);   // requested but invalid
        write_obj(6, 1, 1, 0, 0, 0);
        chk("R2 txrqst vector", 32'(txrqst_o), 32'h64);
    endtask

    task automatic t_gate_and_select();
        repeat (3) begin tick(); chk("R3 no load core not ready", 32'(load_o), 0); end
        core_ready_i = 1'b1; ram_busy_i = 1'b1;
        repeat (3) begin tick(); chk("R3 no load ram busy", {30'd0, load_o, busy_o}, 0); end
        ram_busy_i = 1'b0;
        tick();
        core_ready_i = 1'b0;
        chk("R4 load strobe", 32'(load_o), 1);
        chk("R4 skip invalid, pick 5", 32'(load_idx_o), 5);
        chk("R4 busy", 32'(busy_o), 1);
        chk("R5 newdat cleared", 32'(newdat_o[5]), 0);
        tick();
        chk("R4 single pulse", 32'(load_o), 0);
    endtask

    task automatic t_success_int();
        pulse_ok();
        chk("R6 busy falls", 32'(busy_o), 0);
        chk("R6 request cleared", 32'(txrqst_o[5]), 0);
        chk("R8 intpnd set with txie", 32'(intpnd_o[5]), 1);
    endtask

    task automatic t_newdat_keeps();
        core_ready_i = 1'b1; tick(); core_ready_i = 1'b0;
        chk("R4 load obj6", {28'd0, load_o, load_idx_o}, {28'd0, 1'b1, 3'd6});
        write_obj(6, 1, 1, 1, 0, 0);
        pulse_ok();
        chk("R7 request kept", 32'(txrqst_o[6]), 1);
        chk("R7 newdat still set", 32'(newdat_o[6]), 1);
        chk("R8 no intpnd without txie", 32'(intpnd_o[6]), 0);
    endtask

    task automatic t_retry_arb();
        core_ready_i = 1'b1; tick(); core_ready_i = 1'b0;
        chk("R4 reload obj6", {28'd0, load_o, load_idx_o}, {28'd0, 1'b1, 3'd6});
        arb_lost_i = 1'b1; tick(); arb_lost_i = 1'b0;
        chk("R9 retry wait", {30'd0, busy_o, retry_wait_o}, 3);
        write_obj(1, 1, 1, 0, 0, 0);
        core_ready_i = 1'b1;
        repeat (3) begin
            tick();
            chk("R10 no load while waiting", 32'(load_o), 0);
            chk("R9 still waiting", 32'(retry_wait_o), 1);
        end
        bus_idle_i = 1'b1; tick(); bus_idle_i = 1'b0;
        chk("R9 leaves wait on idle", {30'd0, busy_o, load_o}, 0);
        tick();
        core_ready_i = 1'b0;
        chk("R9 retry re-arbitrated to obj1", {28'd0, load_o, load_idx_o}, {28'd0, 1'b1, 3'd1});
        pulse_ok();
        chk("R6 obj1 request cleared", 32'(txrqst_o[1]), 0);
        chk("R6 obj6 still pending", 32'(txrqst_o[6]), 1);
    endtask

    task automatic t_retry_err();
        core_ready_i = 1'b1; tick(); core_ready_i = 1'b0;
        chk("R4 load obj6 again", {28'd0, load_o, load_idx_o}, {28'd0, 1'b1, 3'd6});
        tx_err_i = 1'b1; tick(); tx_err_i = 1'b0;
        chk("R9 error enters wait", 32'(retry_wait_o), 1);
        bus_idle_i = 1'b1; tick(); bus_idle_i = 1'b0;
        core_ready_i = 1'b1; tick(); core_ready_i = 1'b0;
        chk("R9 obj6 resent", {28'd0, load_o, load_idx_o}, {28'd0, 1'b1, 3'd6});
        pulse_ok();
        chk("R6 obj6 cleared after resend", 32'(txrqst_o[6]), 0);
    endtask

    task automatic t_extremes();
        write_obj(7, 1, 1, 0, 1, 0);
        write_obj(0, 1, 1, 0, 1, 0);
        core_ready_i = 1'b1; tick();
        chk("R4 index 0 beats 7", {28'd0, load_o, load_idx_o}, {28'd0, 1'b1, 3'd0});
        repeat (2) begin tick(); chk("R10 no load while busy", 32'(load_o), 0); end
        pulse_ok();
        chk("R8 intpnd obj0", 32'(intpnd_o[0]), 1);
        tick();
        core_ready_i = 1'b0;
        chk("R4 then index 7", {28'd0, load_o, load_idx_o}, {28'd0, 1'b1, 3'd7});
        pulse_ok();
        chk("R6 all requests done", 32'(txrqst_o & msgval_o), 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_ni = 1'b1;
        tick();
        t_reset();
        t_write();
        t_gate_and_select();
        t_success_int();
        t_newdat_keeps();
        t_retry_arb();
        t_retry_err();
        t_extremes();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule